// File: doc/BRIEF.md
# Two-Phase Timestep Barrier Controller

This block keeps a group of cores in step on a shared discrete time base. The cores exchange typed messages over a common interconnect. Spike messages carry activity between cores, barrier messages tell the controller that a core has finished its neuron sweep for the current step, and management traffic (writes, read requests, read responses) passes by without affecting the time base. The controller watches every message injected into the interconnect and every spike delivery, classifies each message, and keeps a count of spikes that are still in flight.

The controller runs a two-phase barrier. Once every core has reported that it is done, the controller enters the flush phase and stays there until the in-flight spike count reaches zero. It then spends one cycle in the advance phase. In that cycle it raises a timestep-advance broadcast that carries the new timestamp value. After that it returns to the sweep phase with every done flag clear, so the cores may start updating their neurons for the new step. A spike injected by a core that has already reported done for the current step is flagged as a protocol error.

Top module: `tstep_barrier_ctrl`

## Requirements
- R1: The decode outputs are combinational and are all low while `msg_valid_i` is low. Type code 3 raises `is_spike_o` and code 4 raises `is_barrier_o`. Codes 0 (write), 1 (read request) and 2 (read response) raise `is_mgmt_o`. Codes 5 to 7 raise none of them.
- R2: `inflight_o` changes on the clock edge after an event. It rises by one for each valid spike message and falls by one for each `spike_dlv_i` pulse. An injection and a delivery in the same cycle leave it unchanged. A delivery while it reads zero is ignored. An injection while it holds its all-ones maximum is ignored.
- R3: In the sweep phase, a valid barrier message from source core k sets bit k of `done_o` on the next edge.
- R4: `phase_o` encodes 0 as sweep, 1 as flush and 2 as advance. The phase moves from sweep to flush on the first edge at which every bit of `done_o` is already set.
- R5: The flush phase holds while `inflight_o` is nonzero, or while a spike is injected in the same cycle. It moves to advance on the first edge at which `inflight_o` reads zero and no spike is injected.
- R6: The advance phase lasts exactly one cycle. In that cycle `advance_o` is high, `timestamp_o` equals the previous timestamp plus one, and `advance_ts_o` carries that same value. The timestamp is TS_W bits wide, 16 by default, and wraps to zero after its maximum. Outside the advance phase, `advance_ts_o` is zero and `timestamp_o` does not change.
- R7: The advance phase is followed by the sweep phase with every bit of `done_o` clear.
- R8: A valid spike from a core whose `done_o` bit is set pulses `proto_err_o` for one cycle after the edge. The spike is still counted in `inflight_o`.
- R9: Management messages, messages with codes 5 to 7, and barrier messages outside the sweep phase change neither `done_o` nor `inflight_o`.
- R10: While `rst_ni` is low, the phase is sweep and `timestamp_o`, `inflight_o`, `done_o`, `advance_o`, `advance_ts_o` and `proto_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | A message is injected this cycle |
| msg_type_i | input | 3 | Message type code |
| msg_src_i | input | CORE_W | Index of the injecting core |
| spike_dlv_i | input | 1 | One spike reached its destination this cycle |
| is_spike_o | output | 1 | Current message is a spike |
| is_barrier_o | output | 1 | Current message is a barrier |
| is_mgmt_o | output | 1 | Current message is management traffic |
| done_o | output | N_CORES | Per-core sweep-done flags |
| inflight_o | output | CNT_W | Spikes injected but not yet delivered |
| phase_o | output | 2 | Barrier phase |
| advance_o | output | 1 | Timestep-advance broadcast |
| advance_ts_o | output | TS_W | New timestamp carried by the broadcast |
| timestamp_o | output | TS_W | Current timestamp |
| proto_err_o | output | 1 | Spike injected by a core that is already done |

## Verification
The bench holds the barrier in flush with spikes still in flight after every core has reported done. A controller that advanced on done flags alone would broadcast early, and one that ignored injections in the flush cycle would advance with a spike still outstanding. It drives the count into both its floor and its ceiling, where a missing guard would wrap the counter to all-ones or to zero. It also steps the timestamp through its wrap, where a wrong width would show up as a wrong broadcast value. It sends late spikes from cores that are already done, as well as management and reserved type codes, so a missing error flag or a decoder that let stray traffic set done flags would be caught at the ports.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [2:0] {
    MSG_WR      = 3'd0,
    MSG_RD_REQ  = 3'd1,
    MSG_RD_RSP  = 3'd2,
    MSG_SPIKE   = 3'd3,
    MSG_BARRIER = 3'd4
  } msg_type_e;

  typedef enum logic [1:0] {
    PH_SWEEP   = 2'd0,
    PH_FLUSH   = 2'd1,
    PH_ADVANCE = 2'd2
  } phase_e;
endpackage

// File: rtl/tsb_msg_decode.sv
module tsb_msg_decode (
  input  logic       valid_i,
  input  logic [2:0] type_i,
  output logic       spike_o,
  output logic       barrier_o,
  output logic       mgmt_o
);
  import tsb_pkg::*;

  always_comb begin
    spike_o   = 1'b0;
    barrier_o = 1'b0;
    mgmt_o    = 1'b0;
    if (valid_i) begin
      case (type_i)
        MSG_WR, MSG_RD_REQ, MSG_RD_RSP: mgmt_o    = 1'b1;
        MSG_SPIKE:                      spike_o   = 1'b1;
        MSG_BARRIER:                    barrier_o = 1'b1;
        default: ;
      endcase
    end
  end

  // R1: classes are exclusive
  always_comb begin
    a_onehot_class_r1: assert ($onehot0({spike_o, barrier_o, mgmt_o}));
  end
endmodule

// File: rtl/tsb_inflight_cnt.sv
module tsb_inflight_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_req_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             dec_ok;

  assign full    = &cnt_q;
  assign dec_ok  = dec_req_i && (cnt_q != '0);
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case ({inc_i, dec_ok})
        2'b10:   if (!full) cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: ;
      endcase
    end
  end

  p_inc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_req_i && !full) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !inc_i) |=> (cnt_q == '0));

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !dec_req_i) |=> full);
endmodule

// File: rtl/tsb_barrier_fsm.sv
module tsb_barrier_fsm #(
  parameter int N_CORES = 4,
  parameter int TS_W    = 16,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spike_i,
  input  logic              barrier_i,
  input  logic [CORE_W-1:0] src_i,
  input  logic              fabric_empty_i,
  output logic [N_CORES-1:0] done_o,
  output logic [1:0]        phase_o,
  output logic [TS_W-1:0]   ts_o,
  output logic              advance_o,
  output logic [TS_W-1:0]   advance_ts_o,
  output logic              err_o
);
  import tsb_pkg::*;

  phase_e             state_q;
  logic [N_CORES-1:0] done_q;
  logic [N_CORES-1:0] src_hit;
  logic [TS_W-1:0]    ts_q;
  logic               err_q;
  logic               all_done;
  logic               flush_ok;

  for (genvar i = 0; i < N_CORES; i++) begin : g_src
    assign src_hit[i] = (src_i == CORE_W'(i));
  end

  assign all_done = &done_q;
  assign flush_ok = fabric_empty_i && !spike_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_SWEEP;
      done_q  <= '0;
      ts_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= spike_i && |(src_hit & done_q);
      case (state_q)
        PH_SWEEP: begin
          if (barrier_i) done_q <= done_q | src_hit;
          if (all_done)  state_q <= PH_FLUSH;
        end
        PH_FLUSH: begin
          if (flush_ok) begin
            state_q <= PH_ADVANCE;
            ts_q    <= ts_q + TS_W'(1);
          end
        end
        default: begin
          state_q <= PH_SWEEP;
          done_q  <= '0;
        end
      endcase
    end
  end

  assign done_o       = done_q;
  assign phase_o      = state_q;
  assign ts_o         = ts_q;
  assign advance_o    = (state_q == PH_ADVANCE);
  assign advance_ts_o = advance_o ? ts_q : '0;
  assign err_o        = err_q;

  p_flush_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_SWEEP && all_done) |=> (state_q == PH_FLUSH));

  p_wait_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_FLUSH && !fabric_empty_i) |=> (state_q == PH_FLUSH));

  p_adv_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_ADVANCE) |=> (state_q == PH_SWEEP));

  p_ts_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_FLUSH && flush_ok) |=> (ts_q == $past(ts_q) + TS_W'(1)));

  p_ts_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state_q == PH_FLUSH && flush_ok) |=> $stable(ts_q));

  p_done_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_ADVANCE) |=> (done_q == '0));

  p_late_spike_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spike_i && |(src_hit & done_q)) |=> err_q);
endmodule

// File: rtl/tstep_barrier_ctrl.sv
module tstep_barrier_ctrl #(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 10,
  parameter int TS_W    = 16,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic [2:0]         msg_type_i,
  input  logic [CORE_W-1:0]  msg_src_i,
  input  logic               spike_dlv_i,
  output logic               is_spike_o,
  output logic               is_barrier_o,
  output logic               is_mgmt_o,
  output logic [N_CORES-1:0] done_o,
  output logic [CNT_W-1:0]   inflight_o,
  output logic [1:0]         phase_o,
  output logic               advance_o,
  output logic [TS_W-1:0]    advance_ts_o,
  output logic [TS_W-1:0]    timestamp_o,
  output logic               proto_err_o
);
  logic spike;
  logic barrier;
  logic empty;

  tsb_msg_decode i_decode (
    .valid_i   (msg_valid_i),
    .type_i    (msg_type_i),
    .spike_o   (spike),
    .barrier_o (barrier),
    .mgmt_o    (is_mgmt_o)
  );

  tsb_inflight_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (spike),
    .dec_req_i (spike_dlv_i),
    .cnt_o     (inflight_o),
    .empty_o   (empty)
  );

  tsb_barrier_fsm #(.N_CORES(N_CORES), .TS_W(TS_W)) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .spike_i        (spike),
    .barrier_i      (barrier),
    .src_i          (msg_src_i),
    .fabric_empty_i (empty),
    .done_o         (done_o),
    .phase_o        (phase_o),
    .ts_o           (timestamp_o),
    .advance_o      (advance_o),
    .advance_ts_o   (advance_ts_o),
    .err_o          (proto_err_o)
  );

  assign is_spike_o   = spike;
  assign is_barrier_o = barrier;

  // R5: advance only after the fabric drained
  p_adv_after_drain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(advance_o) |-> ($past(inflight_o) == '0));
endmodule

// File: tb/test_tstep_barrier_ctrl.sv
module test_tstep_barrier_ctrl;
  localparam int N  = 4;
  localparam int CW = 4;
  localparam int TW = 4;
  localparam int SW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          msg_valid_i = 1'b0;
  logic [2:0]    msg_type_i = '0;
  logic [SW-1:0] msg_src_i = '0;
  logic          spike_dlv_i = 1'b0;
  logic          is_spike_o, is_barrier_o, is_mgmt_o;
  logic [N-1:0]  done_o;
  logic [CW-1:0] inflight_o;
  logic [1:0]    phase_o;
  logic          advance_o;
  logic [TW-1:0] advance_ts_o, timestamp_o;
  logic          proto_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0]  m_done;
  logic [CW-1:0] m_infl;
  logic [1:0]    m_phase;
  logic [TW-1:0] m_ts;
  logic          m_err;
  int            m_adv;

  tstep_barrier_ctrl #(.N_CORES(N), .CNT_W(CW), .TS_W(TW)) i_tstep_barrier_ctrl (
    .clk_i, .rst_ni, .msg_valid_i, .msg_type_i, .msg_src_i, .spike_dlv_i,
    .is_spike_o, .is_barrier_o, .is_mgmt_o, .done_o, .inflight_o, .phase_o,
    .advance_o, .advance_ts_o, .timestamp_o, .proto_err_o
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_cls(input logic v, input logic [2:0] t);
    if (!v) return 3'b000;
    if (t == 3'd3) return 3'b100;
    if (t == 3'd4) return 3'b010;
    if (t <= 3'd2) return 3'b001;
    return 3'b000;
  endfunction

  task automatic step_model();
    logic spk, bar, dec;
    logic [N-1:0] hit;
    logic [N-1:0] n_done;
    logic [CW-1:0] n_infl;
    logic [1:0] n_phase;
    logic [TW-1:0] n_ts;
    spk = msg_valid_i && msg_type_i == 3'd3;
    bar = msg_valid_i && msg_type_i == 3'd4;
    hit = N'(1) << msg_src_i;
    dec = spike_dlv_i && m_infl != 0;
    n_infl = m_infl;
    if (spk && !dec && m_infl != {CW{1'b1}}) n_infl = m_infl + 1'b1;
    else if (dec && !spk) n_infl = m_infl - 1'b1;
    n_done = m_done; n_phase = m_phase; n_ts = m_ts;
    case (m_phase)
      2'd0: begin
        if (bar) n_done = m_done | hit;
        if (&m_done) n_phase = 2'd1;
      end
      2'd1: if (m_infl == 0 && !spk) begin n_phase = 2'd2; n_ts = m_ts + 1'b1; m_adv++; end
      default: begin n_phase = 2'd0; n_done = '0; end
    endcase
    m_err = spk && ((m_done & hit) != 0);
    m_done = n_done; m_infl = n_infl; m_phase = n_phase; m_ts = n_ts;
  endtask

  task automatic cyc();
    #1;
    chk("R1 decode", {29'd0, is_spike_o, is_barrier_o, is_mgmt_o}, {29'd0, exp_cls(msg_valid_i, msg_type_i)});
    @(posedge clk_i);
    step_model();
    @(negedge clk_i);
    chk("R2 inflight", 32'(inflight_o), 32'(m_infl));
    chk("R3 done", 32'(done_o), 32'(m_done));
    chk("R5 phase", 32'(phase_o), 32'(m_phase));
    chk("R6 advance", 32'(advance_o), 32'(m_phase == 2'd2));
    chk("R6 timestamp", 32'(timestamp_o), 32'(m_ts));
    chk("R6 advance_ts", 32'(advance_ts_o), (m_phase == 2'd2) ? 32'(m_ts) : 32'd0);
    chk("R8 proto_err", 32'(proto_err_o), 32'(m_err));
  endtask

  task automatic send(input logic [2:0] t, input int s, input logic dlv);
    msg_valid_i = 1'b1; msg_type_i = t; msg_src_i = SW'(s); spike_dlv_i = dlv;
    cyc();
    msg_valid_i = 1'b0; msg_type_i = '0; msg_src_i = '0; spike_dlv_i = 1'b0;
  endtask

  task automatic idle(input int n, input logic dlv);
    for (int i = 0; i < n; i++) begin
      spike_dlv_i = dlv;
      cyc();
      spike_dlv_i = 1'b0;
    end
  endtask

  task automatic all_barriers();
    for (int c = 0; c < N; c++) send(3'd4, c, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [N-1:0] d0;
    void'($urandom(32'd20240517));
    m_done = '0; m_infl = '0; m_phase = '0; m_ts = '0; m_err = 0; m_adv = 0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 phase", 32'(phase_o), 0);
    chk("R10 ts", 32'(timestamp_o), 0);
    chk("R10 inflight", 32'(inflight_o), 0);
    chk("R10 done", 32'(done_o), 0);
    chk("R10 adv", {30'd0, advance_o, proto_err_o}, 0);
    chk("R10 adv_ts", 32'(advance_ts_o), 0);
    rst_ni = 1'b1;

    // directed: flush waits for drain
    send(3'd3, 0, 1'b0);
    send(3'd3, 1, 1'b0);
    all_barriers();
    chk("R3 all done", 32'(done_o), 32'hf);
    idle(1, 1'b0);
    chk("R4 enter flush", 32'(phase_o), 1);
    idle(1, 1'b0);
    chk("R5 hold flush", 32'(phase_o), 1);
    idle(2, 1'b1);
    chk("R2 drained", 32'(inflight_o), 0);
    idle(1, 1'b0);
    chk("R6 advance pulse", 32'(advance_o), 1);
    chk("R6 broadcast ts", 32'(advance_ts_o), 1);
    idle(1, 1'b0);
    chk("R7 sweep", 32'(phase_o), 0);
    chk("R7 done cleared", 32'(done_o), 0);
    chk("R6 ts held", 32'(timestamp_o), 1);

    // late spike
    send(3'd4, 2, 1'b0);
    send(3'd3, 2, 1'b0);
    chk("R8 error pulse", 32'(proto_err_o), 1);
    chk("R8 still counted", 32'(inflight_o), 1);
    idle(1, 1'b0);
    chk("R8 pulse ends", 32'(proto_err_o), 0);
    send(3'd4, 0, 1'b0); send(3'd4, 1, 1'b0); send(3'd4, 3, 1'b0);
    idle(2, 1'b0);
    chk("R5 blocked by late spike", 32'(phase_o), 1);
    idle(1, 1'b1);
    idle(2, 1'b0);

    // ignored traffic
    d0 = done_o;
    for (int t = 0; t < 8; t++) if (t != 3 && t != 4) send(3'(t), 1, 1'b0);
    chk("R9 done untouched", 32'(done_o), 32'(d0));
    chk("R9 inflight untouched", 32'(inflight_o), 0);
    send(3'd3, 3, 1'b0);
    send(3'd4, 0, 1'b0); send(3'd4, 1, 1'b0); send(3'd4, 2, 1'b0); send(3'd4, 3, 1'b0);
    idle(1, 1'b0);
    send(3'd4, 1, 1'b0);
    send(3'd1, 2, 1'b0);
    chk("R9 flush traffic ignored", 32'(inflight_o), 1);
    chk("R9 still flush", 32'(phase_o), 1);
    idle(1, 1'b1);
    idle(2, 1'b0);

    // counter ceiling and floor
    for (int i = 0; i < 17; i++) send(3'd3, 0, 1'b0);
    chk("R2 ceiling", 32'(inflight_o), 15);
    idle(18, 1'b1);
    chk("R2 floor", 32'(inflight_o), 0);

    // random steps, through timestamp wrap
    for (int k = 0; k < 20000 && m_adv < 24; k++) begin
      int r, s;
      r = $urandom_range(0, 9);
      s = $urandom_range(0, N - 1);
      msg_valid_i = 1'b0;
      if (r <= 1) begin
        msg_valid_i = 1'b1;
        msg_type_i = (r == 0) ? 3'($urandom_range(0, 2)) : 3'($urandom_range(5, 7));
      end else if (r <= 4) begin
        if (!m_done[s] || $urandom_range(0, 7) == 0) begin
          msg_valid_i = 1'b1; msg_type_i = 3'd3;
        end
      end else if (r <= 6) begin
        msg_valid_i = 1'b1; msg_type_i = 3'd4;
      end
      msg_src_i = SW'(s);
      spike_dlv_i = (m_infl != 0) && ($urandom_range(0, 1) == 1);
      cyc();
    end
    msg_valid_i = 1'b0; spike_dlv_i = 1'b0;
    chk("R6 wrap reached", 32'(m_adv >= 24), 1);
    summary();
  end
endmodule